// File: doc/BRIEF.md
# Mixed-Reset Register File

A small bank of four 8-bit storage registers with a single write port and a single read port. The read side is purely combinational: a 2-bit read select picks one register and its contents appear on the read data output at once, with no clock edge involved. The write side is clocked. When the write enable is high at a rising edge, the data input is stored into the one register chosen by a 2-bit write select. All other registers keep their contents.

Reset does not clear the bank. Each register has its own 8-bit reset constant, supplied as a parameter. A bit whose constant is 1 comes up set, and a bit whose constant is 0 comes up cleared. Reset is active low. It takes hold at once when asserted. Its release is synchronized to the clock through two flip-flops, so the bank only accepts writes once the release has passed that synchronizer.

The block serves as local scratch storage inside a datapath. A control sequencer picks the source and the destination on each cycle.

Top module: `regfile_mixed_reset`

## Requirements
- R1: The bank holds four registers at indices 0 to 3. `rd_sel` equal to index k places register k on `rd_data`.
- R2: `rd_data` follows changes of `rd_sel`, and of register contents, within the same cycle, without waiting for a clock edge.
- R3: A rising edge with `wr_en` = 1 stores `wr_data` into the register indexed by `wr_sel`. The new value is readable right after that edge.
- R4: A write changes only the register indexed by `wr_sel`. The other three registers keep their values.
- R5: A rising edge with `wr_en` = 0 changes no register, whatever `wr_sel` and `wr_data` carry.
- R6: After reset, register k holds its reset constant. With the default parameters these are 0xA5, 0x3C, 0x00 and 0xFF for indices 0 to 3, which mixes set and cleared bits.
- R7: While `rst_n` is low, a write request has no effect, and every register keeps its reset constant.
- R8: Repeating the same write over several edges leaves the target register at the written value, and the other registers unchanged.
- R9: Driving `rst_n` low loads the reset constants immediately, with no clock edge. After `rst_n` rises, writes on the first two rising edges are ignored, and a write on the third rising edge takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rst_n | input | 1 | Active-low reset; asynchronous assertion, synchronized release |
| wr_en | input | 1 | Write request for the current edge |
| wr_sel | input | 2 | Index of the register to write |
| wr_data | input | 8 | Value to store |
| rd_sel | input | 2 | Index of the register to read |
| rd_data | output | 8 | Contents of the selected register, combinational |

## Verification
A reset and a write can both be present in the same cycle, so the bench holds `wr_en` high with a target and data while `rst_n` is low. It then keeps the request asserted straight through the release. It judges the outcome by reading the target register after each edge. The register must show its reset constant until the third edge after release, and the written data after that edge. A second overlap, a write and a combinational read of the same register in one cycle, is checked by reading the target right after the write edge.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

  // Default geometry of the bank
  localparam int unsigned RF_DATA_W = 8;
  localparam int unsigned RF_DEPTH  = 4;

  // Default per-register reset constants, entry k at slice k
  localparam logic [RF_DEPTH-1:0][RF_DATA_W-1:0] RF_RESET_DEFAULT =
    {8'hFF, 8'h00, 8'h3C, 8'hA5};

endpackage

// File: rtl/rf_rst_sync.sv
module rf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned SEL_W = $clog2(DEPTH)
) (
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [DEPTH-1:0] we_o
);

  for (genvar k = 0; k < DEPTH; k++) begin : g_dec
    assign we_o[k] = en_i && (sel_i == SEL_W'(k));
  end

endmodule

// File: rtl/rf_entry.sv
module rf_entry #(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);

  logic [DATA_W-1:0] val_q;
  logic [DATA_W-1:0] val_d;

  // Next-state: explicit clock enable
  always_comb begin
    val_d = val_q;
    if (we_i) begin
      val_d = d_i;
    end
  end

  // Bits with RST_VAL=1 use a preset, the rest a clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= RST_VAL;
    end else begin
      val_q <= val_d;
    end
  end

  assign q_o = val_q;

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni) we_i |=> (q_o == $past(d_i))) else $error("write lost"); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni) !we_i |=> $stable(q_o)) else $error("entry changed without enable"); // R4

endmodule

// File: rtl/rf_read_mux.sv
module rf_read_mux #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned SEL_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][DATA_W-1:0] bank_i,
  input  logic [SEL_W-1:0]             sel_i,
  output logic [DATA_W-1:0]            data_o
);

  always_comb begin
    data_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (sel_i == SEL_W'(k)) begin
        data_o = bank_i[k];
      end
    end
  end

endmodule

// File: rtl/regfile_mixed_reset.sv
module regfile_mixed_reset #(
  parameter int unsigned DATA_W = regfile_pkg::RF_DATA_W,
  parameter int unsigned DEPTH  = regfile_pkg::RF_DEPTH,
  parameter logic [DEPTH-1:0][DATA_W-1:0] RESET_VALUES = regfile_pkg::RF_RESET_DEFAULT,
  localparam int unsigned SEL_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data
);

  logic                         rst_sync_n;
  logic [DEPTH-1:0]             we_vec;
  logic [DEPTH-1:0][DATA_W-1:0] bank;

  rf_rst_sync #(
    .STAGES (2)
  ) u_rst_sync (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_sync_n)
  );

  rf_wr_decode #(
    .DEPTH (DEPTH)
  ) u_wr_decode (
    .en_i  (wr_en),
    .sel_i (wr_sel),
    .we_o  (we_vec)
  );

  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    rf_entry #(
      .DATA_W  (DATA_W),
      .RST_VAL (RESET_VALUES[k])
    ) u_entry (
      .clk_i  (clk),
      .rst_ni (rst_sync_n),
      .we_i   (we_vec[k]),
      .d_i    (wr_data),
      .q_o    (bank[k])
    );
  end

  rf_read_mux #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_read_mux (
    .bank_i (bank),
    .sel_i  (rd_sel),
    .data_o (rd_data)
  );

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_sync_n) $countones(we_vec) == (wr_en ? 1 : 0)) else $error("write decode not one-hot"); // R4
  AST_RELEASE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_sync_n) |-> (bank == RESET_VALUES)) else $error("bank not at reset constants on release"); // R7
  AST_IDLE_BANK: assert property (@(posedge clk) disable iff (!rst_sync_n) !wr_en |=> $stable(bank)) else $error("bank changed without write"); // R5

endmodule

// File: tb/test_regfile_mixed_reset.sv
module test_regfile_mixed_reset;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic [1:0] rd_sel;
  logic [7:0] rd_data;

  int n_tests;
  int n_fail;
  logic [7:0] model [4];

  regfile_mixed_reset i_regfile_mixed_reset (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_sel  (rd_sel),
    .rd_data (rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input int idx, input logic [7:0] exp);
    rd_sel = 2'(idx);
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic model_reset();
    model[0] = 8'hA5; model[1] = 8'h3C; model[2] = 8'h00; model[3] = 8'hFF;
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < 4; k++) read_chk(req, k, model[k]);
  endtask

  task automatic do_write(input int idx, input logic [7:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(idx); wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
    model[idx] = val;
  endtask

  task automatic t_reset_state();
    model_reset();
    check_all("R6 reset constants");
  endtask

  task automatic t_comb_read();
    @(negedge clk);
    for (int k = 3; k >= 0; k--) begin
      read_chk("R1 R2 read without clock", k, model[k]);
    end
  endtask

  task automatic t_single_writes();
    do_write(1, 8'h96);
    read_chk("R3 write to 1", 1, 8'h96);
    check_all("R4 others hold");
    do_write(3, 8'h0E);
    check_all("R4 after write to 3");
    do_write(0, 8'h00);
    do_write(2, 8'hC3);
    check_all("R3 R4 writes 0 and 2");
  endtask

  task automatic t_write_disabled();
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd2; wr_data = 8'h11;
    repeat (3) @(negedge clk);
    check_all("R5 disabled write ignored");
  endtask

  task automatic t_repeat_write();
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h5D;
    model[0] = 8'h5D;
    @(negedge clk);
    read_chk("R8 first write", 0, 8'h5D);
    @(negedge clk);
    read_chk("R8 second pulse", 0, 8'h5D);
    @(negedge clk);
    wr_en = 1'b0;
    check_all("R8 third pulse");
  endtask

  task automatic t_reset_vs_write();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    model_reset();
    check_all("R9 asynchronous reset");
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h5A;
    @(negedge clk);
    @(negedge clk);
    read_chk("R7 reset beats write", 2, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    read_chk("R9 first edge after release", 2, 8'h00);
    @(negedge clk);
    read_chk("R9 second edge after release", 2, 8'h00);
    @(negedge clk);
    wr_en = 1'b0;
    model[2] = 8'h5A;
    read_chk("R9 third edge write lands", 2, 8'h5A);
    check_all("R9 R4 after release");
  endtask

  initial begin
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_comb_read();
    t_single_writes();
    t_write_disabled();
    t_repeat_write();
    t_reset_vs_write();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule